// File: doc/BRIEF.md
# Burst DMA Master for a Peripheral Card

This block sits on a peripheral card and moves bursts of 32-bit words between local buffers and host memory over a shared, synchronous address/data channel. Local logic hands it one command. The command carries a direction, a 32-bit word address (a 34-bit byte address whose two low bits are zero) and a word count. The block first checks the command. A command that would run past a 2048-byte block, that is empty, or that is longer than the configured maximum is refused on the spot, and no bus activity follows.

For a legal command the block drops the matching active-low request line and holds it until the host grants. In the cycle after the grant it drives the packed address. The host never sees a length field. The length is implied by how many cycles the request stays low after the grant, counting the address cycle. Write words are pulled from a local source one per cycle and driven on the bus. Read words are taken from the bus on every cycle the host acknowledges and pushed to a local sink.

If the host flags an error together with its acknowledge, the block ends the transfer in the next cycle. It then waits until it samples acknowledge deasserted before it takes another command, so a lingering acknowledge from the aborted transfer is never read as a fresh grant.

Top module: `dmam_burst_master`

## Requirements
- R1: While reset is high and in the cycle after it, `rreq_n` and `wreq_n` are 1 and `ad_oe` is 0.
- R2: Once a command is accepted, exactly one request line goes low in the next cycle. `wreq_n` is used for a write (`cmd_write`=1) and `rreq_n` for a read. The two lines are never low together.
- R3: A raised request stays low until acknowledge (`ack_n`=0) is sampled at a clock edge. `ad_oe` stays 0 before that edge. In the cycle after it, `ad_oe`=1 and `ad_out` carries the packed address: `ad_out[31:5]` = word address bits 26..0, and `ad_out[4:0]` = word address bits 31..27.
- R4: Let cycle 0 be the address cycle. For an N-word transfer, the request stays low in cycles 0 to N-1 and is high from cycle N on.
- R5: On a write, data word k (counting from 0) is driven on `ad_out` with `ad_oe`=1 in cycle k+1. Word k is the value `wr_data` held when the k-th `wr_pop` edge occurred. In cycle N+1, `ad_oe` is 0 and `xfer_done` pulses.
- R6: On a read, every edge after the address cycle that samples `ack_n`=0 with `err_n`=1 captures `ad_in`. The captured word appears on `rd_data` with `rd_valid`=1 in the next cycle. `xfer_done` pulses together with the N-th word.
- R7: A command whose word offset inside its 2048-byte block (`cmd_waddr[8:0]`) plus its word count exceeds 512 is refused. `cmd_reject` pulses in the next cycle and no request is raised. A transfer that ends exactly on the block boundary is accepted.
- R8: A command with a word count of 0, or a count greater than MAX_WORDS (default 64), is refused in the same way as R7.
- R9: During a transfer, an edge that samples `ack_n`=0 and `err_n`=0 forces both requests high and `ad_oe` to 0 in the next cycle. `xfer_abort` pulses in that cycle, and the word flagged by the error is not pushed.
- R10: After a transfer ends, `cmd_ready` stays 0 and no request is raised until an edge samples `ack_n`=1.
- R11: Byte address bits at or above HOST_BA_W (default 32) are driven as 0. With the default, `ad_out[4:3]` are 0 in the address cycle.
- R12: `cmd_ready` is 1 exactly when the block is idle and able to take a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present, taken when `cmd_ready` is 1 |
| cmd_write | input | 1 | 1 = write to host memory, 0 = read |
| cmd_waddr | input | 32 | Word address (byte address bits 33..2) |
| cmd_words | input | LEN_W (8) | Number of words in the transfer |
| cmd_ready | output | 1 | Idle, able to take a command |
| cmd_reject | output | 1 | One-cycle pulse: command refused |
| xfer_done | output | 1 | One-cycle pulse: transfer completed |
| xfer_abort | output | 1 | One-cycle pulse: transfer ended by a host error |
| wr_data | input | 32 | Local write data, consumed on a `wr_pop` edge |
| wr_pop | output | 1 | `wr_data` is taken at the coming edge |
| rd_valid | output | 1 | `rd_data` holds a fresh read word |
| rd_data | output | 32 | Read word pushed to local sink |
| rreq_n | output | 1 | Active-low read request |
| wreq_n | output | 1 | Active-low write request |
| ack_n | input | 1 | Active-low acknowledge from host |
| err_n | input | 1 | Active-low error from host, valid with acknowledge |
| ad_in | input | 32 | Address/data bus as seen on the channel |
| ad_out | output | 32 | Value the block drives on the bus |
| ad_oe | output | 1 | Bus output enable |

## Verification
Random legal transfers vary the direction, the length from 1 to 64, the word offset, the grant delay and the read latency. This shows whether the request hold time follows the length, independent of when the grant arrives or when read data starts. Exact-fit transfers (offset 448 with 64 words) and one-past-boundary commands show whether the boundary comparison is off by one. Counts of 0 and 65 test the length limit on their own. Errors are injected on the grant edge, in mid-write and in mid-read, each followed by an acknowledge held low. These cases show whether the abort is immediate, whether the flagged read word is dropped, and whether a stale acknowledge is wrongly taken as a new grant. An address with every high bit set shows the masking of unsupported bits.

// File: rtl/dmam_pkg.sv
package dmam_pkg;

  localparam int BUS_W = 32;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_ADDR,
    S_WDATA,
    S_RDATA,
    S_DRAIN
  } dmam_state_e;

  // Clear word-address bits the host cannot reach, then rotate so the
  // top five word-address bits land in the low five bus bits.
  function automatic logic [BUS_W-1:0] dmam_pack_addr(input logic [31:0] waddr,
                                                      input int wa_bits);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = (i < wa_bits) ? waddr[i] : 1'b0;
    return {m[26:0], m[31:27]};
  endfunction

endpackage

// File: rtl/dmam_cnt.sv
module dmam_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] value,
  output logic         zero
);
  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (load) value <= load_val;
    else if (dec)  value <= value - W'(1);
  end
  assign zero = (value == '0);
endmodule

// File: rtl/dmam_cmd_check.sv
module dmam_cmd_check #(
  parameter int MAX_WORDS   = 64,
  parameter int BOUND_WORDS = 512,
  parameter int LEN_W       = 8,
  parameter int OFF_W       = 9
) (
  input  logic [OFF_W-1:0] offset,
  input  logic [LEN_W-1:0] words,
  output logic             ok
);
  localparam int SUM_W = ((OFF_W > LEN_W) ? OFF_W : LEN_W) + 1;

  logic [SUM_W-1:0] end_pos;

  always_comb begin
    end_pos = SUM_W'(offset) + SUM_W'(words);
    ok = (words != '0) &&
         (words <= LEN_W'(MAX_WORDS)) &&
         (end_pos <= SUM_W'(BOUND_WORDS));
  end
endmodule

// File: rtl/dmam_burst_master.sv
module dmam_burst_master
  import dmam_pkg::*;
#(
  parameter int MAX_WORDS   = 64,
  parameter int BOUND_BYTES = 2048,
  parameter int HOST_BA_W   = 32,
  parameter int LEN_W       = $clog2(MAX_WORDS) + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [31:0]      cmd_waddr,
  input  logic [LEN_W-1:0] cmd_words,
  output logic             cmd_ready,
  output logic             cmd_reject,
  output logic             xfer_done,
  output logic             xfer_abort,
  input  logic [31:0]      wr_data,
  output logic             wr_pop,
  output logic             rd_valid,
  output logic [31:0]      rd_data,
  output logic             rreq_n,
  output logic             wreq_n,
  input  logic             ack_n,
  input  logic             err_n,
  input  logic [31:0]      ad_in,
  output logic [31:0]      ad_out,
  output logic             ad_oe
);
  localparam int BOUND_WORDS = BOUND_BYTES / 4;
  localparam int OFF_W       = $clog2(BOUND_WORDS);
  localparam int WA_BITS     = HOST_BA_W - 2;

  dmam_state_e      state;
  logic             dir_wr, req_q, cmd_ok;
  logic [31:0]      waddr_q;
  logic [LEN_W-1:0] words_q;
  logic             ack, err, in_xfer, hit_err, granted, rd_take;
  logic             req_dec, beat_ld, beat_dec, req_zero, beat_zero;
  logic [LEN_W-1:0] req_val, beat_val, beat_ld_val;

  assign ack = ~ack_n;
  assign err = ~err_n;

  dmam_cmd_check #(
    .MAX_WORDS(MAX_WORDS), .BOUND_WORDS(BOUND_WORDS), .LEN_W(LEN_W), .OFF_W(OFF_W)
  ) u_check (
    .offset(cmd_waddr[OFF_W-1:0]), .words(cmd_words), .ok(cmd_ok)
  );

  always_comb begin
    in_xfer     = (state == S_REQ) || (state == S_ADDR) ||
                  (state == S_WDATA) || (state == S_RDATA);
    hit_err     = in_xfer && ack && err;
    granted     = (state == S_REQ) && ack && !err;
    req_dec     = ((state == S_ADDR) || (state == S_WDATA) || (state == S_RDATA)) &&
                  !req_zero && !hit_err;
    beat_ld     = (state == S_ADDR) && !hit_err;
    beat_ld_val = dir_wr ? (words_q - LEN_W'(1)) : words_q;
    rd_take     = (state == S_RDATA) && ack && !err;
    wr_pop      = !hit_err && (((state == S_ADDR) && dir_wr) ||
                               ((state == S_WDATA) && !beat_zero));
    beat_dec    = ((state == S_WDATA) && !hit_err && !beat_zero) || rd_take;
  end

  // Cycles the request stays low after the address cycle
  dmam_cnt #(.W(LEN_W)) u_req_cnt (
    .clk(clk), .rst(rst), .load(granted), .load_val(words_q - LEN_W'(1)),
    .dec(req_dec), .value(req_val), .zero(req_zero)
  );

  // Data words still to move
  dmam_cnt #(.W(LEN_W)) u_beat_cnt (
    .clk(clk), .rst(rst), .load(beat_ld), .load_val(beat_ld_val),
    .dec(beat_dec), .value(beat_val), .zero(beat_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      dir_wr     <= 1'b0;
      req_q      <= 1'b0;
      waddr_q    <= '0;
      words_q    <= '0;
      ad_out     <= '0;
      ad_oe      <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      cmd_reject <= 1'b0;
      xfer_done  <= 1'b0;
      xfer_abort <= 1'b0;
    end else begin
      cmd_reject <= 1'b0;
      xfer_done  <= 1'b0;
      xfer_abort <= 1'b0;
      rd_valid   <= 1'b0;
      if (hit_err) begin
        req_q      <= 1'b0;
        ad_oe      <= 1'b0;
        ad_out     <= '0;
        xfer_abort <= 1'b1;
        state      <= S_DRAIN;
      end else begin
        unique case (state)
          S_IDLE: if (cmd_valid) begin
            if (cmd_ok) begin
              dir_wr  <= cmd_write;
              waddr_q <= cmd_waddr;
              words_q <= cmd_words;
              req_q   <= 1'b1;
              state   <= S_REQ;
            end else begin
              cmd_reject <= 1'b1;
            end
          end
          S_REQ: if (ack) begin
            ad_out <= dmam_pack_addr(waddr_q, WA_BITS);
            ad_oe  <= 1'b1;
            state  <= S_ADDR;
          end
          S_ADDR: begin
            if (req_zero) req_q <= 1'b0;
            if (dir_wr) begin
              ad_out <= wr_data;
              state  <= S_WDATA;
            end else begin
              ad_out <= '0;
              ad_oe  <= 1'b0;
              state  <= S_RDATA;
            end
          end
          S_WDATA: begin
            if (req_zero) req_q <= 1'b0;
            if (beat_zero) begin
              ad_out    <= '0;
              ad_oe     <= 1'b0;
              req_q     <= 1'b0;
              xfer_done <= 1'b1;
              state     <= S_DRAIN;
            end else begin
              ad_out <= wr_data;
            end
          end
          S_RDATA: begin
            if (req_zero) req_q <= 1'b0;
            if (rd_take) begin
              rd_valid <= 1'b1;
              rd_data  <= ad_in;
              if (beat_val == LEN_W'(1)) begin
                req_q     <= 1'b0;
                xfer_done <= 1'b1;
                state     <= S_DRAIN;
              end
            end
          end
          S_DRAIN: if (!ack) state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign cmd_ready = (state == S_IDLE);
  assign rreq_n    = !(req_q && !dir_wr);
  assign wreq_n    = !(req_q && dir_wr);

  logic unused_ok;
  assign unused_ok = ^req_val;
endmodule

// File: rtl/dmam_burst_master_chk.sv
module dmam_burst_master_chk (
  input logic clk,
  input logic rst,
  input logic cmd_ready,
  input logic cmd_reject,
  input logic rreq_n,
  input logic wreq_n,
  input logic ack_n,
  input logic err_n,
  input logic ad_oe
);
  logic req_any, granted_q, stale_q;
  assign req_any = !rreq_n || !wreq_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      granted_q <= 1'b0;
      stale_q   <= 1'b0;
    end else begin
      if (req_any && !ack_n)  granted_q <= 1'b1;
      else if (!req_any)      granted_q <= 1'b0;
      if (!cmd_ready && !ack_n && !err_n) stale_q <= 1'b1;
      else if (ack_n)                     stale_q <= 1'b0;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (rreq_n && wreq_n && !ad_oe));

  // R2
  one_req_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rreq_n && !wreq_n));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_any && !granted_q && ack_n) |=> req_any);

  // R9
  err_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd_ready && !ack_n && !err_n) |=> (rreq_n && wreq_n && !ad_oe));

  // R10
  stale_ack_chk: assert property (@(posedge clk) disable iff (rst)
    stale_q |-> (rreq_n && wreq_n && !cmd_ready));

  // R7
  reject_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_reject |-> (rreq_n && wreq_n && cmd_ready));
endmodule

bind dmam_burst_master dmam_burst_master_chk u_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .cmd_reject(cmd_reject),
  .rreq_n(rreq_n), .wreq_n(wreq_n), .ack_n(ack_n), .err_n(err_n), .ad_oe(ad_oe)
);

// File: tb/dmam_burst_master_bench.sv
module dmam_burst_master_bench;
  localparam int LEN_W = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 0, cmd_write = 0;
  logic [31:0] cmd_waddr = '0;
  logic [LEN_W-1:0] cmd_words = '0;
  logic cmd_ready, cmd_reject, xfer_done, xfer_abort, wr_pop, rd_valid;
  logic [31:0] wr_data, rd_data, ad_out;
  logic [31:0] ad_in = '0;
  logic rreq_n, wreq_n, ad_oe;
  logic ack_n = 1'b1, err_n = 1'b1;
  int wcnt;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dmam_burst_master u_dmam_burst_master (.*);

  function automatic logic [31:0] wpat(int k);
    return {16'hA5C3 ^ k[15:0], ~k[15:0]};
  endfunction
  function automatic logic [31:0] rpat(int k, int salt);
    return (32'h3C5A_0000 + salt * 32'h0001_0003) ^ (k * 32'h0103_0507);
  endfunction
  // R11: bits 31:30 of the word address unsupported with HOST_BA_W=32
  function automatic logic [31:0] pack(logic [31:0] w);
    return {w[26:0], 2'b00, w[29:27]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) wcnt <= 0;
    else if (wr_pop) wcnt <= wcnt + 1;
  end
  assign wr_data = wpat(wcnt);

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Abort aftermath: acknowledge held low must not be taken as a grant
  task automatic stale_phase();
    repeat (2) begin
      @(negedge clk);
      chk(!cmd_ready && rreq_n && wreq_n, "R10 stale ack", {cmd_ready, rreq_n, wreq_n}, 3'b011);
    end
    ack_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && rreq_n && wreq_n, "R10 release", {cmd_ready, rreq_n, wreq_n}, 3'b111);
  endtask

  task automatic abort_check(string tag);
    chk(xfer_abort && rreq_n && wreq_n && !ad_oe && !rd_valid, tag,
        {xfer_abort, rreq_n, wreq_n, ad_oe, rd_valid}, 5'b11100);
    err_n = 1'b1;
    stale_phase();
  endtask

  // err_at: -1 none, 0 on grant, k>0 on data word k (1-based)
  task automatic xfer(bit wr, logic [31:0] wa, int n, int gd, int lat, int err_at, int salt);
    int i, w0;
    @(negedge clk);
    chk(cmd_ready, "R12 ready before command", cmd_ready, 1);
    cmd_valid = 1; cmd_write = wr; cmd_waddr = wa; cmd_words = LEN_W'(n);
    @(negedge clk);
    cmd_valid = 0;
    chk(!cmd_ready, "R12 busy", cmd_ready, 0);
    chk(wr ? (!wreq_n && rreq_n) : (!rreq_n && wreq_n), "R2 request line",
        {rreq_n, wreq_n}, wr ? 2'b10 : 2'b01);
    for (int g = 0; g < gd; g++) begin
      @(negedge clk);
      chk((wr ? !wreq_n : !rreq_n) && !ad_oe, "R3 hold before grant",
          {rreq_n, wreq_n, ad_oe}, wr ? 3'b100 : 3'b010);
    end
    ack_n = 1'b0;
    if (err_at == 0) err_n = 1'b0;
    @(negedge clk);
    if (err_at == 0) begin abort_check("R9 grant error"); return; end
    ack_n = 1'b1;
    w0 = wcnt;
    chk(ad_oe && ad_out == pack(wa), "R3 R11 address cycle", {ad_oe, ad_out}, {1'b1, pack(wa)});
    chk(wr ? !wreq_n : !rreq_n, "R4 request in address cycle", {rreq_n, wreq_n}, 0);
    if (wr) begin
      for (int j = 1; j <= n; j++) begin
        @(negedge clk);
        chk(ad_oe && ad_out == wpat(w0 + j - 1), "R5 write word", ad_out, wpat(w0 + j - 1));
        chk(wreq_n == (j >= n), "R4 write request length", wreq_n, (j >= n));
        ack_n = 1'b0;
        if (j == err_at) begin
          err_n = 1'b0;
          @(negedge clk);
          abort_check("R9 write error");
          return;
        end
      end
      @(negedge clk);
      chk(!ad_oe && xfer_done && wreq_n && rreq_n, "R5 write end",
          {ad_oe, xfer_done, wreq_n, rreq_n}, 4'b0111);
      ack_n = 1'b1;
    end else begin
      i = 0;
      for (int t = 0; t < lat; t++) begin
        @(negedge clk); i++;
        chk(rreq_n == (i >= n), "R4 read request length", rreq_n, (i >= n));
      end
      for (int k = 0; k <= n; k++) begin
        @(negedge clk); i++;
        if (k > 0 && err_at == k) begin
          ack_n = 1'b0;
          abort_check("R9 read error");
          return;
        end
        chk(rreq_n == (i >= n), "R4 read request length", rreq_n, (i >= n));
        if (k > 0) begin
          chk(rd_valid && rd_data == rpat(k - 1, salt), "R6 read word", rd_data, rpat(k - 1, salt));
          chk(xfer_done == (k == n), "R6 done pulse", xfer_done, (k == n));
        end
        if (k < n) begin
          ack_n = 1'b0; ad_in = rpat(k, salt);
          if (err_at == k + 1) err_n = 1'b0;
        end else begin
          ack_n = 1'b1; ad_in = '0;
        end
      end
    end
    @(negedge clk);
    chk(cmd_ready, "R12 ready after drain", cmd_ready, 1);
  endtask

  task automatic reject(logic [31:0] wa, int n, string tag);
    @(negedge clk);
    cmd_valid = 1; cmd_write = n[0]; cmd_waddr = wa; cmd_words = LEN_W'(n);
    @(negedge clk);
    cmd_valid = 0;
    chk(cmd_reject && rreq_n && wreq_n && cmd_ready, tag,
        {cmd_reject, rreq_n, wreq_n, cmd_ready}, 4'b1111);
    @(negedge clk);
    chk(!cmd_reject && rreq_n && wreq_n, tag, {cmd_reject, rreq_n, wreq_n}, 3'b011);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(rreq_n && wreq_n && !ad_oe, "R1 during reset", {rreq_n, wreq_n, ad_oe}, 3'b110);
    rst = 0;
    @(negedge clk);
    chk(rreq_n && wreq_n && !ad_oe && cmd_ready, "R1 after reset",
        {rreq_n, wreq_n, ad_oe, cmd_ready}, 4'b1101);

    xfer(1, 32'h0000_1000, 1, 0, 0, -1, 1);
    xfer(0, 32'h0000_2004, 1, 0, 0, -1, 2);
    xfer(1, 32'h0000_31C0, 64, 1, 0, -1, 3);    // R7 ends exactly on boundary
    xfer(0, 32'h0000_41C0, 64, 2, 1, -1, 4);    // R7 exact fit, read
    xfer(0, 32'h1234_5008, 4, 2, 3, -1, 5);
    xfer(1, 32'hFFFF_FE00, 3, 0, 0, -1, 6);     // R11 high bits masked
    reject(32'h0000_01F4, 20, "R7 boundary crossing");
    reject(32'h0000_01C1, 64, "R7 one past boundary");
    reject(32'h0000_0000, 0, "R8 zero length");
    reject(32'h0000_0000, 65, "R8 over maximum");
    xfer(0, 32'h0000_5010, 5, 1, 2, 2, 7);      // R9 read error on word 2
    xfer(1, 32'h0000_6020, 6, 0, 0, 3, 8);      // R9 write error on word 3
    xfer(0, 32'h0000_7000, 8, 1, 0, 0, 9);      // R9 error on grant
    xfer(1, 32'h0000_8000, 2, 0, 0, -1, 10);    // R10 fresh grant after abort

    for (int r = 0; r < 30; r++) begin
      int n, off, gd, lat;
      logic [31:0] wa;
      n   = 1 + int'($urandom % 64);
      off = int'($urandom % (513 - n));
      gd  = int'($urandom % 4);
      lat = int'($urandom % 4);
      wa  = {$urandom, 9'd0} | 32'(off);
      xfer($urandom % 2 == 1, wa, n, gd, lat, -1, 100 + r);
    end
    finish_run();
  end
endmodule